// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

A bank of up to 32 general-purpose pins controlled over a simple 32-bit register bus. Each pin is configured independently. It can be a general input, a general output driven from a data register, or an interrupt source. An interrupt source can sense a level or an edge. A per-pin polarity bit selects high/rising or low/falling, and a both-edge bit makes an edge pin fire on any transition.

Pad inputs pass through a two-flop synchroniser before any use. Each interrupt pin has a pending flag:

- A level pin's flag tracks its qualified input level.
- An edge pin's flag holds until software clears it by writing a one to that bit of the clear register.

Enables are changed through two registers. Writing zeros to the mask register disables pins. Writing ones to the unmask register enables pins. A single registered request line is raised while any pending pin is also enabled.

The bus is synchronous. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are high. A read returns its data on `bus_rdata` one cycle after the address is presented.

Top module: `pio_bank`

## Requirements
- R1: After reset every configuration register reads 0. This means all pins are inputs in general mode, with positive polarity, level sensing, both-edge off, every pin disabled and nothing pending. `pad_oe`, `pad_out` and `irq` are 0.
- R2: A pin with direction bit 1 (offset 0x04) and mode bit 0 (offset 0x00) drives `pad_out` with its output-data bit (offset 0x08) XOR its polarity bit (offset 0x20), and has `pad_oe` 1. A pin in interrupt mode (mode bit 1) never has `pad_oe` set. Both outputs are registered one cycle after the register write.
- R3: Reading offset 0x0C returns the output-data bit for output pins. For input pins it returns the synchronised pad XOR polarity. A pad change is not visible to a read that registers its data on the second clock edge after the change.
- R4: A level-sensing pin (edge bit at 0x24 = 0) in interrupt mode has a pending bit (offset 0x10) equal to its pad XOR polarity, delayed by the synchroniser. Clearing it while still active leaves it set.
- R5: An edge-sensing pin with both-edge 0 sets its pending bit on a rising pad edge when polarity is 0, or on a falling edge when polarity is 1. The bit stays set after the pad returns.
- R6: With the both-edge bit (offset 0x4C) at 1, an edge pin sets its pending bit on either transition, regardless of polarity.
- R7: Writing offset 0x14 clears each pending bit written as 1. Bits written as 0 are unchanged.
- R8: Writing offset 0x18 disables every pin written as 0 and leaves pins written as 1 unchanged. Writing 1s to offset 0x1C enables those pins. Reading 0x18 returns the enabled set.
- R9: `irq` is 1, one cycle after the state, exactly when some pin is both pending and enabled.
- R10: A pin in general mode never has a pending bit, whatever its edge settings or pad activity.
- R11: The filter-enable (offset 0x28) and both-edge (offset 0x4C) registers read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Driven pad levels |
| pad_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situations to reach are those where configuration and pad history interact. Examples are a level pin cleared while its input is still active, or an edge pin whose pad has already returned to idle.

For each table vector, the bench sets the pad to a start level and then configures the pin. It lets the synchroniser settle and clears all pending bits. Only then does it apply the second pad level. This way only the final transition, or the final level, decides the result.

Mask behaviour is checked with a pending bit held latched, so `irq` can move only through the enable registers.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int OFS_W = 7;
  typedef logic [OFS_W-1:0] ofs_t;

  localparam ofs_t OFS_MODE   = 7'h00;
  localparam ofs_t OFS_DIR    = 7'h04;
  localparam ofs_t OFS_ODATA  = 7'h08;
  localparam ofs_t OFS_IDATA  = 7'h0C;
  localparam ofs_t OFS_STAT   = 7'h10;
  localparam ofs_t OFS_CLR    = 7'h14;
  localparam ofs_t OFS_MASK   = 7'h18;
  localparam ofs_t OFS_UNMASK = 7'h1C;
  localparam ofs_t OFS_POL    = 7'h20;
  localparam ofs_t OFS_EDGE   = 7'h24;
  localparam ofs_t OFS_FILT   = 7'h28;
  localparam ofs_t OFS_BOTH   = 7'h4C;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_detect.sv
// Per-pin pending logic: level pins track the qualified level, edge pins latch.
module pio_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad_s,
  input  logic [NPINS-1:0] mode,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] edge_sel,
  input  logic [NPINS-1:0] both,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] status
);
  logic [NPINS-1:0] pad_prev;

  always_ff @(posedge clk) begin
    if (rst) pad_prev <= '0;
    else     pad_prev <= pad_s;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic lvl_now, lvl_old, hit, nxt;
    always_comb begin
      lvl_now = pad_s[i] ^ pol[i];
      lvl_old = pad_prev[i] ^ pol[i];
      hit     = both[i] ? (pad_s[i] ^ pad_prev[i]) : (lvl_now & ~lvl_old);
      if (edge_sel[i]) nxt = (status[i] & ~clr[i]) | hit;  // a new event wins over a clear
      else             nxt = lvl_now;
      nxt = nxt & mode[i];
    end
    always_ff @(posedge clk) begin
      if (rst) status[i] <= 1'b0;
      else     status[i] <= nxt;
    end
  end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [6:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  logic [NPINS-1:0] r_mode, r_dir, r_odata, r_pol, r_edge, r_filt, r_both, r_en;
  logic [NPINS-1:0] pad_s, status, clr_vec, wd, idata_view;
  logic [31:0]      rd_mux;
  logic             wr_en, rd_en;

  assign wd    = bus_wdata[NPINS-1:0];
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  pio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pad_s)
  );

  assign clr_vec = (wr_en && bus_addr == OFS_CLR) ? wd : '0;

  pio_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst(rst), .pad_s(pad_s), .mode(r_mode), .pol(r_pol),
    .edge_sel(r_edge), .both(r_both), .clr(clr_vec), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      r_mode <= '0; r_dir <= '0; r_odata <= '0; r_pol <= '0;
      r_edge <= '0; r_filt <= '0; r_both <= '0; r_en <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        OFS_MODE:   r_mode  <= wd;
        OFS_DIR:    r_dir   <= wd;
        OFS_ODATA:  r_odata <= wd;
        OFS_POL:    r_pol   <= wd;
        OFS_EDGE:   r_edge  <= wd;
        OFS_FILT:   r_filt  <= wd;
        OFS_BOTH:   r_both  <= wd;
        OFS_MASK:   r_en    <= r_en & wd;
        OFS_UNMASK: r_en    <= r_en | wd;
        default: ;
      endcase
    end
  end

  assign idata_view = (r_dir & r_odata) | (~r_dir & (pad_s ^ r_pol));

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_MODE:  rd_mux[NPINS-1:0] = r_mode;
      OFS_DIR:   rd_mux[NPINS-1:0] = r_dir;
      OFS_ODATA: rd_mux[NPINS-1:0] = r_odata;
      OFS_IDATA: rd_mux[NPINS-1:0] = idata_view;
      OFS_STAT:  rd_mux[NPINS-1:0] = status;
      OFS_MASK:  rd_mux[NPINS-1:0] = r_en;
      OFS_POL:   rd_mux[NPINS-1:0] = r_pol;
      OFS_EDGE:  rd_mux[NPINS-1:0] = r_edge;
      OFS_FILT:  rd_mux[NPINS-1:0] = r_filt;
      OFS_BOTH:  rd_mux[NPINS-1:0] = r_both;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      pad_out   <= '0;
      pad_oe    <= '0;
      irq       <= 1'b0;
    end else begin
      if (rd_en) bus_rdata <= rd_mux;
      pad_out <= r_odata ^ r_pol;
      pad_oe  <= r_dir & ~r_mode;
      irq     <= |(status & r_en);
    end
  end
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
  import pio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [6:0]       bus_addr,
  input logic [NPINS-1:0] r_en,
  input logic [NPINS-1:0] r_mode,
  input logic [NPINS-1:0] r_dir,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq
);
  // R9: request reflects pending-and-enabled of the previous cycle
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(status) & $past(r_en))));

  // R10: general-mode pins carry no pending bit
  p_no_pend_general_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(r_mode)) == '0));

  // R2: output enable only for general-mode outputs
  p_oe_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pad_oe == ($past(r_dir) & ~$past(r_mode))));

  // R8: enables rise only through the unmask register
  p_en_rise_r8: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr && bus_addr == OFS_UNMASK) |=> ((r_en & ~$past(r_en)) == '0));

  // R8: enables fall only through the mask register
  p_en_fall_r8: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr && bus_addr == OFS_MASK) |=> (($past(r_en) & ~r_en) == '0));
endmodule

bind pio_bank pio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .r_en(r_en), .r_mode(r_mode), .r_dir(r_dir), .status(status),
  .pad_oe(pad_oe), .irq(irq)
);

// File: tb/pio_bank_tb.sv
module pio_bank_tb;
  import pio_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pio_bank u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // {pol, edge, both, pad_start, pad_end, expected pending}
  localparam logic [5:0] VEC [12] = '{
    6'b000_01_1, // R4 level high becomes active
    6'b000_10_0, // R4 level high goes inactive
    6'b100_10_1, // R4 level low becomes active
    6'b100_01_0, // R4 level low goes inactive
    6'b010_01_1, // R5 rising edge
    6'b010_10_0, // R5 falling ignored with pol 0
    6'b110_10_1, // R5 falling edge with pol 1
    6'b110_01_0, // R5 rising ignored with pol 1
    6'b011_01_1, // R6 both-edge rise
    6'b011_10_1, // R6 both-edge fall
    6'b111_10_1, // R6 both-edge fall, pol 1
    6'b010_11_0  // R5 no transition
  };

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input ofs_t a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input ofs_t a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input ofs_t a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    chk_reg("R1 mode", OFS_MODE, 32'h0);
    chk_reg("R1 dir", OFS_DIR, 32'h0);
    chk_reg("R1 mask", OFS_MASK, 32'h0);
    chk_reg("R1 status", OFS_STAT, 32'h0);
    chk_reg("R1 pol", OFS_POL, 32'h0);
    chk_reg("R1 edge", OFS_EDGE, 32'h0);

    // R11 readback
    wr(OFS_FILT, 32'h1234_5678);
    wr(OFS_BOTH, 32'h0000_F00F);
    chk_reg("R11 filt", OFS_FILT, 32'h1234_5678);
    chk_reg("R11 both", OFS_BOTH, 32'h0000_F00F);
    wr(OFS_BOTH, 32'h0);

    // table-driven trigger modes
    for (int i = 0; i < 12; i++) begin
      int p;
      logic [31:0] bit_p;
      p = i * 2 + 1;
      bit_p = 32'h1 << p;
      pad_in = VEC[i][2] ? bit_p : 32'h0;
      wr(OFS_POL,  VEC[i][5] ? bit_p : 32'h0);
      wr(OFS_EDGE, VEC[i][4] ? bit_p : 32'h0);
      wr(OFS_BOTH, VEC[i][3] ? bit_p : 32'h0);
      wr(OFS_MODE, bit_p);
      idle(5);
      wr(OFS_CLR, 32'hFFFF_FFFF);
      idle(2);
      pad_in = VEC[i][1] ? bit_p : 32'h0;
      idle(5);
      rd(OFS_STAT, v);
      check($sformatf("R4/R5/R6 vector %0d", i), v, VEC[i][0] ? bit_p : 32'h0);
      wr(OFS_MODE, 32'h0);
    end
    pad_in = '0;
    wr(OFS_POL, 32'h0); wr(OFS_EDGE, 32'h0); wr(OFS_BOTH, 32'h0);

    // R2 output drive
    wr(OFS_ODATA, 32'hA5A5_0001);
    wr(OFS_DIR, 32'h0000_FFFF);
    wr(OFS_POL, 32'h0000_000F);
    idle(1);
    check("R2 pad_out", pad_out, 32'hA5A5_000E);
    check("R2 pad_oe", pad_oe, 32'h0000_FFFF);
    wr(OFS_MODE, 32'h0000_0001);
    idle(1);
    check("R2 interrupt pin not driven", pad_oe, 32'h0000_FFFE);
    wr(OFS_MODE, 32'h0);

    // R3 input data view
    pad_in = 32'hFFFF_0000;
    idle(4);
    chk_reg("R3 idata", OFS_IDATA, 32'hFFFF_0001);
    wr(OFS_POL, 32'h00F0_000F);
    chk_reg("R3 idata pol", OFS_IDATA, 32'hFF0F_0001);
    wr(OFS_POL, 32'h0);
    pad_in = 32'hFFFF_0000;
    @(negedge clk);
    pad_in[31] = 1'b0;
    rd(OFS_IDATA, v);
    check("R3 sync latency old", v & 32'h8000_0000, 32'h8000_0000);
    rd(OFS_IDATA, v);
    check("R3 sync latency new", v & 32'h8000_0000, 32'h0);
    pad_in = '0; wr(OFS_DIR, 32'h0); wr(OFS_ODATA, 32'h0);
    idle(4);

    // R5 latch, R7 write-one-to-clear
    wr(OFS_EDGE, 32'h0000_0008);
    wr(OFS_MODE, 32'h0000_0008);
    wr(OFS_CLR, 32'hFFFF_FFFF);
    pad_in = 32'h0000_0008;
    idle(5);
    pad_in = 32'h0;
    idle(5);
    chk_reg("R5 latched after pad returns", OFS_STAT, 32'h0000_0008);
    wr(OFS_CLR, 32'hFFFF_FFF7);
    chk_reg("R7 zero bits no effect", OFS_STAT, 32'h0000_0008);
    wr(OFS_CLR, 32'h0000_0008);
    chk_reg("R7 one bit clears", OFS_STAT, 32'h0);

    // R8 / R9 masking
    pad_in = 32'h0000_0008;
    idle(5);
    check("R9 pending but disabled", {31'b0, irq}, 32'h0);
    wr(OFS_UNMASK, 32'h0000_0008);
    idle(1);
    check("R9 irq after unmask", {31'b0, irq}, 32'h1);
    chk_reg("R8 mask readback", OFS_MASK, 32'h0000_0008);
    wr(OFS_MASK, 32'hFFFF_FFFF);
    chk_reg("R8 ones leave unchanged", OFS_MASK, 32'h0000_0008);
    wr(OFS_MASK, 32'hFFFF_FFF7);
    idle(1);
    check("R8 zero disables irq", {31'b0, irq}, 32'h0);
    chk_reg("R8 mask after disable", OFS_MASK, 32'h0);
    wr(OFS_UNMASK, 32'h0000_0008);
    wr(OFS_CLR, 32'h0000_0008);
    idle(1);
    check("R9 irq drops after clear", {31'b0, irq}, 32'h0);

    // R4 level recomputed after clear
    wr(OFS_MODE, 32'h0000_0028);
    pad_in = 32'h0000_0028;
    idle(4);
    wr(OFS_CLR, 32'h0000_0020);
    idle(2);
    chk_reg("R4 level stays after clear", OFS_STAT, 32'h0000_0020);

    // R10 general-mode pin with edge settings
    wr(OFS_MODE, 32'h0);
    wr(OFS_EDGE, 32'h0000_0080);
    wr(OFS_BOTH, 32'h0000_0080);
    pad_in = 32'h0000_0080;
    idle(4);
    pad_in = 32'h0;
    idle(4);
    chk_reg("R10 no pending in general mode", OFS_STAT, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule